// File: doc/BRIEF.md
# Strobed Overvoltage Filter with Blanking Selector

This block watches the auxiliary-winding sense voltage of a quasi-resonant flyback controller through two digitized comparator bits, one for the overvoltage level and one for a 1 V level. During each switch-off interval it opens a short sample window. The window starts a fixed delay after turn-off, so that the leakage ringing has settled before any sample is taken. Comparator activity outside that window is ignored.

An over-threshold sample marks the current oscillator cycle as a hit. At each oscillator tick, a hit cycle advances a saturating run counter and a clean cycle resets it to zero. When the run reaches `HIT_RUN` consecutive cycles, a sticky overvoltage fault is raised. The fault stays up until the restart sequencer pulses `faultClr`.

The same window also picks the next blanking time for the turn-on controller. If the sense voltage is below 1 V at the last window sample, the long blanking is selected. This is the normal case during start-up or with a shorted output. If it is above 1 V, the short blanking is selected.

Top module: `ovp_strobe_filter`

## Requirements
- R1: With `gateOff` high, the cycle in which it first reads high is off-cycle 0. A sample is taken only in off-cycles `STROBE_DLY` through `STROBE_DLY+WIN_LEN-1`. `ovpCmp` outside those cycles, or while `gateOff` is low, has no effect on the fault.
- R2: An oscillator period is a hit if at least one in-window sample had `ovpCmp`=1. This includes a sample in the same cycle as the `oscTick` pulse. At each `oscTick` a hit period advances the run count, which saturates at `HIT_RUN`.
- R3: At an `oscTick` that closes a period with no hit, the run count returns to zero. The next fault then needs a fresh run of `HIT_RUN` hits.
- R4: `ovpFault` goes to 1 on the clock edge of the `oscTick` that closes the `HIT_RUN`-th consecutive hit period, and not earlier.
- R5: `ovpFault` stays 1 until `faultClr` is sampled high. `faultClr` clears the fault, the run count and any pending hit, and it takes priority over a simultaneous tick.
- R6: In the last window cycle (off-cycle `STROBE_DLY+WIN_LEN-1`), `blankLong` is loaded with the inverse of `oneVoltCmp`. `oneVoltCmp`=1 means the sense voltage is above 1 V, which selects short blanking (`blankLong`=0). `oneVoltCmp`=0 selects long blanking (`blankLong`=1).
- R7: An off interval that ends before the last window cycle leaves `blankLong` unchanged. In-window hits from that interval still count toward the run.
- R8: After reset, `ovpFault`=0 and `blankLong`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| gateOff | input | 1 | High while the power switch is off |
| oscTick | input | 1 | One-cycle pulse at each oscillator period end |
| ovpCmp | input | 1 | Sense voltage above overvoltage level |
| oneVoltCmp | input | 1 | Sense voltage above 1 V |
| faultClr | input | 1 | Clear pulse from the restart sequencer |
| ovpFault | output | 1 | Sticky overvoltage fault |
| blankLong | output | 1 | 1 selects long blanking, 0 short |

## Verification
The bench sweeps every 6-period hit/clean pattern, so runs of exactly three hits, runs broken by one clean period, and runs longer than four all occur.

- A counter that only decremented on a clean period, or never reset, would fault on scattered hits.
- An off-by-one run length would fault one period early or late.

Comparator pulses are placed one cycle before and one cycle after the window, and on its first and last cycles. A window shifted by a cycle therefore shows up as a spurious or a missing fault.

Short off intervals that close before the last window cycle check two things together. The blanking select must hold its previous value, while the partial-window hit must still count.

// File: rtl/ovp_strobe_pkg.sv
package ovp_strobe_pkg;
  // Strobes passed from the timing control to the datapath
  typedef struct packed {
    logic sampleEn;   // inside the sample window
    logic windowEnd;  // last cycle of the sample window
    logic cycleEnd;   // oscillator period boundary
  } strobe_t;
endpackage

// File: rtl/ovp_strobe_ctrl.sv
module ovp_strobe_ctrl
  import ovp_strobe_pkg::*;
#(
  parameter int STROBE_DLY = 110,
  parameter int WIN_LEN    = 25
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    gateOff,
  input  logic    oscTick,
  output strobe_t strobe
);
  localparam int LAST = STROBE_DLY + WIN_LEN;
  localparam int TW   = $clog2(LAST + 1);
  localparam logic [TW-1:0] DLY_V  = TW'(STROBE_DLY);
  localparam logic [TW-1:0] LAST_V = TW'(LAST);
  localparam logic [TW-1:0] END_V  = TW'(LAST - 1);

  logic [TW-1:0] offCnt;

  // Off-interval timer, saturates once the window has passed
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              offCnt <= '0;
    else if (!gateOff)      offCnt <= '0;
    else if (offCnt != LAST_V) offCnt <= offCnt + 1'b1;
  end

  always_comb begin
    strobe.sampleEn  = gateOff && (offCnt >= DLY_V) && (offCnt < LAST_V);
    strobe.windowEnd = gateOff && (offCnt == END_V);
    strobe.cycleEnd  = oscTick;
  end
endmodule

// File: rtl/ovp_strobe_dp.sv
module ovp_strobe_dp
  import ovp_strobe_pkg::*;
#(
  parameter int HIT_RUN = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobe,
  input  logic    ovpCmp,
  input  logic    oneVoltCmp,
  input  logic    faultClr,
  output logic    ovpFault,
  output logic    blankLong
);
  localparam int CW = $clog2(HIT_RUN + 1);
  localparam logic [CW-1:0] RUN_V  = CW'(HIT_RUN);
  localparam logic [CW-1:0] TRIP_V = CW'(HIT_RUN - 1);

  logic [CW-1:0] hitCnt;
  logic          hitSeen;
  logic          hitNow;

  assign hitNow = hitSeen | (strobe.sampleEn & ovpCmp);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitCnt   <= '0;
      hitSeen  <= 1'b0;
      ovpFault <= 1'b0;
    end else if (faultClr) begin
      hitCnt   <= '0;
      hitSeen  <= 1'b0;
      ovpFault <= 1'b0;
    end else if (strobe.cycleEnd) begin
      hitSeen <= 1'b0;
      if (hitNow) begin
        if (hitCnt != RUN_V) hitCnt <= hitCnt + 1'b1;
        if (hitCnt >= TRIP_V) ovpFault <= 1'b1;
      end else begin
        hitCnt <= '0;
      end
    end else begin
      hitSeen <= hitNow;
    end
  end

  // Blanking select taken from the last window sample
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 blankLong <= 1'b1;
    else if (strobe.windowEnd) blankLong <= ~oneVoltCmp;
  end
endmodule

// File: rtl/ovp_strobe_filter.sv
module ovp_strobe_filter
  import ovp_strobe_pkg::*;
#(
  parameter int STROBE_DLY = 110,
  parameter int WIN_LEN    = 25,
  parameter int HIT_RUN    = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic gateOff,
  input  logic oscTick,
  input  logic ovpCmp,
  input  logic oneVoltCmp,
  input  logic faultClr,
  output logic ovpFault,
  output logic blankLong
);
  strobe_t strobe;

  ovp_strobe_ctrl #(.STROBE_DLY(STROBE_DLY), .WIN_LEN(WIN_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .gateOff(gateOff), .oscTick(oscTick), .strobe(strobe)
  );

  ovp_strobe_dp #(.HIT_RUN(HIT_RUN)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ovpCmp(ovpCmp),
    .oneVoltCmp(oneVoltCmp), .faultClr(faultClr),
    .ovpFault(ovpFault), .blankLong(blankLong)
  );
endmodule

// File: rtl/ovp_strobe_filter_chk.sv
module ovp_strobe_filter_chk (
  input logic clk,
  input logic rstN,
  input logic gateOff,
  input logic oscTick,
  input logic faultClr,
  input logic ovpFault,
  input logic blankLong
);
  // R4: a fault can only appear on an oscillator tick edge
  p_fault_on_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovpFault) |-> $past(oscTick));

  // R5: fault stays up until a clear arrives
  p_fault_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ovpFault && !faultClr) |=> ovpFault);

  // R5: a clear always drops the fault
  p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    faultClr |=> !ovpFault);

  // R6: the blanking select only moves while the switch is off
  p_blank_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !gateOff |=> $stable(blankLong));
endmodule

bind ovp_strobe_filter ovp_strobe_filter_chk u_chk (.*);

// File: tb/ovp_strobe_filter_bench.sv
module ovp_strobe_filter_bench;
  localparam int DLY = 4;
  localparam int WIN = 3;
  localparam int RUN = 4;
  localparam time CLK_P = 20ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic gateOff = 1'b0, oscTick = 1'b0, ovpCmp = 1'b0, oneVoltCmp = 1'b0, faultClr = 1'b0;
  logic ovpFault, blankLong;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  int  expCnt  = 0;
  bit  expFault = 1'b0;
  bit  expBlank = 1'b1;

  always #(CLK_P/2) clk = ~clk;

  ovp_strobe_filter #(.STROBE_DLY(DLY), .WIN_LEN(WIN), .HIT_RUN(RUN)) u_ovp_strobe_filter (
    .clk(clk), .rstN(rstN), .gateOff(gateOff), .oscTick(oscTick), .ovpCmp(ovpCmp),
    .oneVoltCmp(oneVoltCmp), .faultClr(faultClr), .ovpFault(ovpFault), .blankLong(blankLong)
  );

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // mode: 0 no hit (ovp high while gate on), 1 whole-interval hit,
  // 2 pulses just outside the window, 3 first window cycle, 4 last window cycle
  task automatic runPeriod(input int mode, input int offLen, input bit oneHi);
    bit hit;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      gateOff = 1'b0; oscTick = 1'b0;
      ovpCmp = (mode == 0);
    end
    for (int k = 0; k < offLen; k++) begin
      @(negedge clk);
      gateOff = 1'b1; oneVoltCmp = oneHi;
      case (mode)
        1: ovpCmp = 1'b1;
        2: ovpCmp = (k == DLY - 1) || (k == DLY + WIN);
        3: ovpCmp = (k == DLY);
        4: ovpCmp = (k == DLY + WIN - 1);
        default: ovpCmp = 1'b0;
      endcase
    end
    @(negedge clk);
    gateOff = 1'b0; ovpCmp = 1'b0; oscTick = 1'b1;
    @(negedge clk);
    oscTick = 1'b0;
    hit = (mode == 1 && offLen > DLY) || (mode == 3 && offLen > DLY) ||
          (mode == 4 && offLen >= DLY + WIN);
    if (offLen >= DLY + WIN) expBlank = !oneHi;
    if (hit) begin
      if (expCnt < RUN) expCnt++;
      if (expCnt >= RUN) expFault = 1'b1;
    end else begin
      expCnt = 0;
    end
    if (hit) check("R2/R4 run count and fault", ovpFault, expFault);
    else     check("R1/R3 clean period resets run", ovpFault, expFault);
    if (offLen >= DLY + WIN) check("R6 blanking select", blankLong, expBlank);
    else                     check("R7 short interval holds blanking", blankLong, expBlank);
  endtask

  task automatic clearFault();
    @(negedge clk);
    faultClr = 1'b1;
    @(negedge clk);
    faultClr = 1'b0;
    expFault = 1'b0; expCnt = 0;
    check("R5 clear drops fault", ovpFault, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset fault", ovpFault, 1'b0);
    check("R8 reset blanking long", blankLong, 1'b1);
    rstN = 1'b1;
    @(negedge clk);

    // Exhaustive 6-period hit/clean patterns
    for (int pat = 0; pat < 64; pat++) begin
      clearFault();
      for (int i = 0; i < 6; i++) begin
        bit h = pat[i];
        int md = h ? (1 + (i + pat) % 3 == 2 ? 4 : ((i + pat) % 3 == 0 ? 1 : 3)) : ((i + pat) % 2 == 0 ? 0 : 2);
        int len = ((i + pat) % 5 == 4) ? (DLY + WIN - 1) : (DLY + WIN + 2);
        bit one = pat[(i + 1) % 6] ^ i[0];
        if (len < DLY + WIN && md == 4) md = 1;
        runPeriod(md, len, one);
      end
      // R5: fault persists with no clear through a clean period
      if (expFault) begin
        runPeriod(0, DLY + WIN + 2, 1'b1);
        check("R5 fault sticky", ovpFault, 1'b1);
      end
    end

    // Directed: exact run boundary, then break and resume
    clearFault();
    for (int i = 0; i < RUN - 1; i++) runPeriod(3, DLY + WIN + 2, 1'b0);
    check("R4 no fault after three hits", ovpFault, 1'b0);
    runPeriod(2, DLY + WIN + 2, 1'b0);
    runPeriod(4, DLY + WIN + 2, 1'b1);
    check("R3 broken run gives no fault", ovpFault, 1'b0);
    for (int i = 0; i < RUN - 1; i++) runPeriod(1, DLY + WIN + 2, 1'b1);
    check("R4 fault after fresh run", ovpFault, 1'b1);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule